// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Four-Word Lines

This block is a data cache between a processor that accesses one 32-bit word at a time and a slower word-wide memory. It is direct mapped, with 256 lines of four consecutive words each. Every line has a tag, a valid bit and a dirty bit. Read hits and write hits finish in the same cycle they are presented. A write hit changes only the cached copy and marks the line dirty.

On a miss the block raises its stall output and takes over the memory port. If the line being replaced is valid and dirty, the block first copies that line out to memory. It then loads the whole aligned four-word block that holds the requested word, one word per memory handshake. After that the held request completes as an ordinary hit. On a write miss this hit is the write that merges the processor word and marks the line dirty. The processor must hold its request steady while the stall output is high.

Top module: `wb_cache`

## Requirements
- R1: The address is split as follows. Bits [1:0] are the byte within a word and play no part. Bits [3:2] pick the word inside the line. Bits [11:4] pick one of 256 lines. Bits [31:12] form the tag. Two addresses with the same bits [11:4] and different tags compete for the same line.
- R2: After reset no memory transfer is under way, the stall output is low and every line is invalid. The first access to any line therefore misses and never causes a write-back.
- R3: A refill reads the four words of the aligned block with increasing word offset: block base +0, +4, +8, +12, with mem_we low. The line is then installed with the new tag.
- R4: A read hit returns the cached word picked by bits [3:2], with no memory transfer, in the cycle it is presented.
- R5: A write hit stores cpu_wdata into the cached word with no memory transfer and sets the line's dirty bit. Memory keeps its old value until the line is evicted.
- R6: A miss on a valid, dirty line first writes the four old words back with mem_we high, at the old tag's block addresses, in increasing offset order. Only after the fourth write does the refill of the new block begin.
- R7: A miss on an invalid line, or on a valid clean line, causes no write-back. The refill starts straight away.
- R8: A write miss allocates the line. It refills the block and then merges the processor word. The line is left dirty, so a later eviction writes back the merged word.
- R9: From the cycle a miss is detected until the line is installed, cpu_stall is high while cpu_req is high. A miss costs 1 + 4*(B) stalled cycles without a write-back, and 1 + 8*(B) with one, where B is the number of cycles each memory beat takes.
- R10: Each memory word moves in one handshake. mem_req, mem_we and mem_addr stay stable until mem_ready is sampled high. For reads, mem_rdata is taken in that same cycle.
- R11: cpu_addr bits [1:0] have no effect. Offsets 0x10C and 0x10E return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Word read, valid when cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 32 | Word-aligned memory address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, taken when mem_ready is high |
| mem_ready | input | 1 | Memory accepts or completes the beat this cycle |

## Verification
The bench uses several access patterns, each aimed at telling one behaviour apart from its neighbours:
- A cold read followed by hits at every offset, including one with non-zero byte bits. This separates offset selection from refill ordering.
- A write hit, a conflicting read at another tag and a read at a third tag. Together these tell a dirty eviction from a clean one, and show whether written data reaches memory only at eviction.
- A write miss to an empty line followed by a conflicting read. This shows that allocation merges the word and leaves the line dirty.
- The cases are run with memory beat latencies of zero, one and two wait cycles, which exposes miscounted stalls and handshake slips.

// File: rtl/wbc_pkg.sv
// Package: shared types for the write-back cache.
// Assumes nothing beyond IEEE 1800-2017.
package wbc_pkg;

    // Controller phases: idle/hit service, victim write-back, block refill.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } wbc_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
// Module: wbc_tag_store
// Holds tag, valid and dirty state for each line, with one combinational
// lookup port. Valid bits clear on reset. Tag and dirty bits are not reset:
// they count only when valid is set.
// Assumes mark_dirty and fill_done never occur in the same cycle.
module wbc_tag_store #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    output logic [TAG_W-1:0]   lk_tag,
    output logic               lk_valid,
    output logic               lk_dirty,
    input  logic               mark_dirty,
    input  logic               fill_done,
    input  logic [TAG_W-1:0]   fill_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Lookup of the addressed line.
    always_comb begin
        lk_tag   = tag_q[lk_idx];
        lk_valid = valid_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
    end

    // Valid bits: cleared on reset, set when a refill completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_done) begin
            valid_q[lk_idx] <= 1'b1;
        end
    end

    // Dirty bits: set by a write hit, cleared by a refill install.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            dirty_q[lk_idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[lk_idx] <= 1'b1;
        end
    end

    // Tags: written when a refill completes.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[lk_idx] <= fill_tag;
        end
    end

    // R2
    reset_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    // R5
    write_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |=> dirty_q[$past(lk_idx)]);

    // R3
    install_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (valid_q[$past(lk_idx)] && !dirty_q[$past(lk_idx)]));

endmodule

// File: rtl/wbc_data_store.sv
// Module: wbc_data_store
// Word storage: LINES x WORDS words. It has one combinational read port and
// one synchronous write port. The write port serves either a processor write
// hit or a refill beat, never both.
// Assumes the caller picks the read offset (processor offset or beat count).
module wbc_data_store #(
    parameter int INDEX_W = 8,
    parameter int OFFS_W  = 2,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] rd_idx,
    input  logic [OFFS_W-1:0]  rd_off,
    output logic [WORD_W-1:0]  rd_word,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [OFFS_W-1:0]  wr_off,
    input  logic [WORD_W-1:0]  wr_word
);
    localparam int DEPTH = 1 << (INDEX_W + OFFS_W);

    logic [WORD_W-1:0] words_q [DEPTH];

    // Read the selected word of the selected line.
    always_comb begin
        rd_word = words_q[{rd_idx, rd_off}];
    end

    // Write one word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[{wr_idx, wr_off}] <= wr_word;
        end
    end

endmodule

// File: rtl/wbc_ctrl.sv
// Module: wbc_ctrl
// Miss-handling state machine. Idle serves hits. A miss goes to EVICT when
// the victim is valid and dirty, otherwise straight to REFILL. Each phase
// moves 2**OFFS_W words, one per cycle with mem_ready high, in rising offset.
// After a refill the held request is served in IDLE as a hit.
// Assumes cpu_req, cpu_we and cpu_addr are held while cpu_stall is high.
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int OFFS_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ready,
    output wbc_state_e        state,
    output logic [OFFS_W-1:0] beat,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mark_dirty,
    output logic              fill_beat,
    output logic              fill_done
);
    localparam logic [OFFS_W-1:0] LAST_BEAT = '1;

    wbc_state_e        state_q, state_d;
    logic [OFFS_W-1:0] beat_q, beat_d;
    logic              cpu_done;

    assign state = state_q;
    assign beat  = beat_q;

    // Decode of the per-cycle strobes from the current phase.
    always_comb begin
        cpu_done   = (state_q == ST_IDLE) && cpu_req && hit;
        cpu_stall  = cpu_req && !cpu_done;
        mark_dirty = cpu_done && cpu_we;
        mem_req    = (state_q != ST_IDLE);
        mem_we     = (state_q == ST_EVICT);
        fill_beat  = (state_q == ST_REFILL) && mem_ready;
        fill_done  = fill_beat && (beat_q == LAST_BEAT);
    end

    // Next phase and beat count.
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = '0;
                if (cpu_req && !hit) begin
                    state_d = victim_dirty ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                if (mem_ready) begin
                    beat_d = beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        state_d = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                if (mem_ready) begin
                    beat_d = beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    // Phase and beat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // R10
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(beat_q)));

    // R6
    evict_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ready && beat_q == LAST_BEAT)
            |=> (state_q == ST_REFILL && beat_q == '0));

    // R7
    clean_miss_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !hit && !victim_dirty) |=> (state_q == ST_REFILL));

    // R2
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!mem_req && beat_q == '0));

endmodule

// File: rtl/wb_cache.sv
// Module: wb_cache (top)
// Direct-mapped write-back cache with multi-word lines. It splits the
// processor address, does the tag compare and steers the data-store ports
// and the memory beat address between processor service, write-back and
// refill.
// Assumes the processor holds its request while stalled, and that memory
// keeps mem_rdata valid whenever it raises mem_ready for a read.
module wb_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int INDEX_W = 8,
    parameter int OFFS_W  = 2,
    parameter int BYTE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFS_W - BYTE_W;
    localparam int IDX_LSB = BYTE_W + OFFS_W;
    localparam int TAG_LSB = IDX_LSB + INDEX_W;
    localparam logic [OFFS_W-1:0] LAST_OFF = '1;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic [OFFS_W-1:0]  req_off;
    logic [TAG_W-1:0]   lk_tag;
    logic               lk_valid;
    logic               lk_dirty;
    logic               hit;
    logic               victim_dirty;
    wbc_state_e         state;
    logic [OFFS_W-1:0]  beat;
    logic               mark_dirty;
    logic               fill_beat;
    logic               fill_done;
    logic [OFFS_W-1:0]  rd_off;
    logic [WORD_W-1:0]  rd_word;
    logic               wr_en;
    logic [OFFS_W-1:0]  wr_off;
    logic [WORD_W-1:0]  wr_word;

    // Address fields of the held processor request.
    always_comb begin
        req_tag = cpu_addr[TAG_LSB +: TAG_W];
        req_idx = cpu_addr[IDX_LSB +: INDEX_W];
        req_off = cpu_addr[BYTE_W +: OFFS_W];
    end

    // Tag compare; a victim counts as dirty only if it is also valid.
    always_comb begin
        hit          = lk_valid && (lk_tag == req_tag);
        victim_dirty = lk_valid && lk_dirty;
    end

    // Data-store port steering for hits, write-back and refill.
    always_comb begin
        rd_off  = (state == ST_IDLE) ? req_off : beat;
        wr_en   = mark_dirty || fill_beat;
        wr_off  = fill_beat ? beat : req_off;
        wr_word = fill_beat ? mem_rdata : cpu_wdata;
    end

    // Memory beat address: old tag while evicting, request tag while refilling.
    always_comb begin
        if (state == ST_EVICT) begin
            mem_addr = {lk_tag, req_idx, beat, {BYTE_W{1'b0}}};
        end else begin
            mem_addr = {req_tag, req_idx, beat, {BYTE_W{1'b0}}};
        end
        mem_wdata = rd_word;
        cpu_rdata = rd_word;
    end

    wbc_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (req_idx),
        .lk_tag     (lk_tag),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .mark_dirty (mark_dirty),
        .fill_done  (fill_done),
        .fill_tag   (req_tag)
    );

    wbc_data_store #(
        .INDEX_W (INDEX_W),
        .OFFS_W  (OFFS_W),
        .WORD_W  (WORD_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_off  (rd_off),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (req_idx),
        .wr_off  (wr_off),
        .wr_word (wr_word)
    );

    wbc_ctrl #(
        .OFFS_W (OFFS_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .mem_ready    (mem_ready),
        .state        (state),
        .beat         (beat),
        .cpu_stall    (cpu_stall),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mark_dirty   (mark_dirty),
        .fill_beat    (fill_beat),
        .fill_done    (fill_done)
    );

    // R10
    mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    // R3
    refill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we && mem_addr[BYTE_W +: OFFS_W] != LAST_OFF)
            |=> (mem_req && !mem_we &&
                 mem_addr[BYTE_W +: OFFS_W] == OFFS_W'($past(mem_addr[BYTE_W +: OFFS_W]) + 1'b1)));

    // R9
    stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cpu_req) |-> cpu_stall);

    // R6
    evict_addr_stays_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[IDX_LSB +: INDEX_W] == req_idx));

endmodule

// File: tb/tb_wb_cache.sv
`timescale 1ns/1ps
module tb_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int mem_lat = 0;
    int wait_cnt = 0;

    logic [31:0] mstore [logic [31:0]];
    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];
    logic        lg_we   [64];
    int          lg_n = 0;

    always #2 clk = ~clk;

    wb_cache dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a * 32'h9E37_79B1 + 32'h0001_3579;
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mstore.exists(a)) return mstore[a];
        return pat(a);
    endfunction

    // Memory responder: raises ready after mem_lat wait cycles per beat.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end
        if (rst_n && mem_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_ready = 1'b1;
                mem_rdata = mem_rd(mem_addr);
            end else begin
                wait_cnt++;
            end
        end
    end

    // Beat log and memory update at accepted handshakes.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (lg_n < 64) begin
                lg_addr[lg_n] = mem_addr;
                lg_we[lg_n]   = mem_we;
                lg_data[lg_n] = mem_we ? mem_wdata : mem_rdata;
            end
            if (mem_we) mstore[mem_addr] = mem_wdata;
            lg_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        #0.5;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #0.5;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #0.5;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // Checks the logged beats: nw write-backs from wbase, then nr refills from rbase.
    task automatic chk_beats(input int nw, input logic [31:0] wbase, input int nr,
                             input logic [31:0] rbase, input string req);
        chk(lg_n == nw + nr, req, lg_n, nw + nr);
        for (int i = 0; i < nw + nr && i < lg_n; i++) begin
            logic [31:0] ea;
            ea = (i < nw) ? wbase + 4 * i : rbase + 4 * (i - nw);
            chk(lg_addr[i] == ea, req, lg_addr[i], ea);
            chk(lg_we[i] == (i < nw), req, lg_we[i], (i < nw));
        end
    endtask

    task automatic t_reset();
        chk(cpu_stall == 1'b0, "R2 stall after reset", cpu_stall, 0);
        chk(mem_req == 1'b0, "R2 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_cold_read();
        logic [31:0] rd; int st;
        mem_lat = 0;
        cpu_op(1'b0, 32'h0000_0104, '0, rd, st);
        // R2 R3: empty line, no write-back, refill 0x100..0x10C
        chk_beats(0, '0, 4, 32'h0000_0100, "R3 cold refill");
        chk(rd == pat(32'h104), "R3 cold read data", rd, pat(32'h104));
        // R9: 1 + 4*1
        chk(st == 5, "R9 clean miss stall lat0", st, 5);
    endtask

    task automatic t_hits();
        logic [31:0] rd; int st;
        for (int k = 0; k < 4; k++) begin
            cpu_op(1'b0, 32'h100 + 4 * k, '0, rd, st);
            chk(rd == pat(32'h100 + 4 * k), "R4 hit data", rd, pat(32'h100 + 4 * k));
            chk(lg_n == 0 && st == 0, "R4 hit no traffic", lg_n, 0);
        end
        cpu_op(1'b0, 32'h0000_010E, '0, rd, st);
        chk(rd == pat(32'h10C), "R11 byte bits ignored", rd, pat(32'h10C));
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; int st;
        cpu_op(1'b1, 32'h0000_0108, 32'hDEAD_BEEF, rd, st);
        chk(lg_n == 0 && st == 0, "R5 write hit no traffic", lg_n, 0);
        cpu_op(1'b0, 32'h0000_0108, '0, rd, st);
        chk(rd == 32'hDEAD_BEEF, "R5 write hit readback", rd, 32'hDEAD_BEEF);
        chk(!mstore.exists(32'h108), "R5 memory untouched", 0, 0);
    endtask

    task automatic t_dirty_evict();
        logic [31:0] rd; int st;
        mem_lat = 1;
        // R1: 0x1108 shares index 0x10 with 0x108, tag 1
        cpu_op(1'b0, 32'h0000_1108, '0, rd, st);
        chk_beats(4, 32'h0000_0100, 4, 32'h0000_1100, "R6 evict then refill");
        chk(lg_data[0] == pat(32'h100), "R6 wb word0", lg_data[0], pat(32'h100));
        chk(lg_data[2] == 32'hDEAD_BEEF, "R6 wb written word", lg_data[2], 32'hDEAD_BEEF);
        chk(lg_data[3] == pat(32'h10C), "R6 wb word3", lg_data[3], pat(32'h10C));
        chk(rd == pat(32'h1108), "R1 new tag data", rd, pat(32'h1108));
        // R9: 1 + 8*2
        chk(st == 17, "R9 dirty miss stall lat1", st, 17);
    endtask

    task automatic t_clean_evict();
        logic [31:0] rd; int st;
        mem_lat = 2;
        cpu_op(1'b0, 32'h0000_2100, '0, rd, st);
        chk_beats(0, '0, 4, 32'h0000_2100, "R7 clean victim not written");
        chk(rd == pat(32'h2100), "R7 data", rd, pat(32'h2100));
        // R9: 1 + 4*3
        chk(st == 13, "R9 clean miss stall lat2", st, 13);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int st;
        mem_lat = 0;
        cpu_op(1'b1, 32'h0000_3204, 32'h1234_5678, rd, st);
        chk_beats(0, '0, 4, 32'h0000_3200, "R8 write miss refill");
        cpu_op(1'b0, 32'h0000_3204, '0, rd, st);
        chk(rd == 32'h1234_5678, "R8 merged word", rd, 32'h1234_5678);
        cpu_op(1'b0, 32'h0000_3200, '0, rd, st);
        chk(rd == pat(32'h3200), "R8 neighbour word", rd, pat(32'h3200));
        cpu_op(1'b0, 32'h0000_4208, '0, rd, st);
        chk_beats(4, 32'h0000_3200, 4, 32'h0000_4200, "R8 allocated line dirty");
        chk(lg_data[1] == 32'h1234_5678, "R8 merged written back", lg_data[1], 32'h1234_5678);
        chk(mem_rd(32'h3204) == 32'h1234_5678, "R8 memory updated", mem_rd(32'h3204), 32'h1234_5678);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        t_reset();
        t_cold_read();
        t_hits();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule